// File: doc/BRIEF.md
# Serial Ethernet Frame Transmitter

This block turns one buffered Ethernet frame into a single-bit stream for an external 10 Mb/s serial transceiver. All of its logic runs on the transmit clock that the transceiver supplies, and it sends one bit per clock. After a start request it reads the header and payload bytes from a byte-wide buffer through a combinational read port. The header is made of the destination address, the source address and the type/length field, 14 bytes in all. The block then produces the line image by itself: a 7-byte run of 0x55, a 0xD5 delimiter, the buffered bytes, zero padding and the CRC-32 check word. Transmit enable is held high for the whole of that image.

Carrier sense is the OR of the receive-enable and collision inputs. If carrier is present when a request arrives, the block waits until the line has been quiet for 96 bit times. If collision rises while the block is sending, it cuts the frame short with a 32-bit jam, drops transmit enable and raises a collision flag. A request with a payload length above 1500 bytes sends nothing and sets an error flag.

The controller has seven states. IDLE goes to DEFER on a request that sees carrier, goes to PREAMBLE on a request that sees a quiet line, and stays in IDLE on an oversize request. DEFER goes to PREAMBLE once the quiet timer expires. PREAMBLE goes to BODY after 64 bits. BODY goes to FCS after the last data or pad bit. FCS goes to FINISH after 32 bits. A collision in PREAMBLE, BODY or FCS goes to JAM, and JAM goes to FINISH after 32 bits. FINISH returns to IDLE.

Top module: `eth_ser_tx`

## Requirements
- R1: When `start` is sampled high in IDLE with a legal length and carrier sense is low, `tx_en` is high in the next cycle. The first 64 bits on `txd` are seven bytes of 0x55 followed by one byte of 0xD5, each byte sent least significant bit first.
- R2: After the delimiter the block sends buffer bytes 0 through 13+`pay_len`-1, in address order and LSB first. During that time `rd_addr` is the index of the byte being sent, and `rd_data` is taken in the same cycle.
- R3: When `pay_len` is below 46, zero bytes follow the payload until 46 data bytes have been sent. When `pay_len` is 46 or more, no padding is added.
- R4: The last 32 bits are the complemented IEEE 802.3 CRC-32, computed over every byte from the destination address through the padding with the register preset to all ones, and sent LSB first. A reflected CRC run over the whole frame after the delimiter, check word included, therefore leaves the residue 0xDEBB20E3.
- R5: `tx_en` stays high without a gap for exactly (8+14+max(`pay_len`,46)+4)×8 cycles. In the cycle after the last bit, `tx_en` is low and `done` is high for one cycle.
- R6: A request that sees carrier sense high does not transmit. Transmission begins 97 cycles after carrier sense is first sampled low, which means 96 consecutive quiet cycles followed by the move into PREAMBLE.
- R7: Carrier sense is `rx_en` OR `col`. Either input on its own causes the deferral described in R6.
- R8: If `col` is sampled high during PREAMBLE, BODY or FCS, the next 32 bits are the jam pattern 1,0,1,0,… After that, `tx_en` falls, `done` pulses and `col_flag` is high until the next accepted request.
- R9: A request with `pay_len` greater than 1500 sets `len_err`. Nothing is transmitted, and `tx_en`, `busy` and `done` all stay low. The next legal request clears `len_err`.
- R10: While reset is asserted, `txd`, `tx_en`, `busy`, `done`, `col_flag` and `len_err` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock from the transceiver, one bit per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to send the buffered frame; taken only in IDLE |
| pay_len | input | 11 | Payload length in bytes, not counting the 14 header bytes |
| rd_addr | output | 11 | Buffer byte index being sent |
| rd_data | input | 8 | Buffer byte at `rd_addr`, combinational read |
| rx_en | input | 1 | Receive enable from the transceiver |
| col | input | 1 | Collision indication from the transceiver |
| txd | output | 1 | Serial transmit data |
| tx_en | output | 1 | Transmit enable, active high |
| busy | output | 1 | High whenever the controller is not in IDLE |
| done | output | 1 | One-cycle pulse when a frame or jam ends |
| col_flag | output | 1 | The last frame ended in a collision |
| len_err | output | 1 | The last request was rejected for its length |

## Verification
The main path is exercised with a table of frames whose payload lengths lie on both sides of the padding boundary (0, 1, 45, 46, 47) and reach as far as the 1500-byte maximum. Each frame uses its own buffer fill, so that a swapped byte order or a misplaced pad cannot go unseen. Each frame is rebuilt bit by bit from `txd`. The preamble, the buffered bytes and the pad region are compared separately, the total enable length is checked against the padded size, and the CRC residue is checked. Two frames are hit by a collision, one in the preamble and one in the body, which shows the jam length, the jam pattern and the flag. Two directed deferral runs, one driven by receive-enable and one by collision, pin the 97-cycle restart point and show the OR. An oversize request shows the rejection.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DEFER,
        S_PRE,
        S_BODY,
        S_FCS,
        S_JAM,
        S_FIN
    } tx_state_e;

    localparam logic [7:0]  PRE_BYTE   = 8'h55;
    localparam logic [7:0]  SFD_BYTE   = 8'hD5;
    localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;

endpackage

// File: rtl/etx_crc32.sv
module etx_crc32 (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic upd,
    input  logic shft,
    input  logic din,
    output logic fcs_bit
);
    import eth_tx_pkg::*;

    logic [31:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (init) begin
            crc_q <= '1;
        end else if (upd) begin
            crc_q <= (crc_q >> 1) ^ ((crc_q[0] ^ din) ? CRC_POLY_R : 32'h0);
        end else if (shft) begin
            crc_q <= crc_q >> 1;
        end
    end

    assign fcs_bit = ~crc_q[0];

endmodule

// File: rtl/etx_defer.sv
module etx_defer #(
    parameter int IFG_BITS = 96
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    output logic quiet
);
    localparam int QW = $clog2(IFG_BITS + 1);

    logic [QW-1:0] qcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qcnt <= '0;
        end else if (cs) begin
            qcnt <= '0;
        end else if (qcnt != QW'(IFG_BITS)) begin
            qcnt <= qcnt + 1'b1;
        end
    end

    assign quiet = (qcnt == QW'(IFG_BITS));

    // R6: the quiet indication only follows a cycle in which the line was sampled idle
    a_r6_quiet_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |-> $past(!cs));

endmodule

// File: rtl/eth_ser_tx.sv
module eth_ser_tx #(
    parameter int LEN_W     = 11,
    parameter int HDR_BYTES = 14,
    parameter int MIN_PAY   = 46,
    parameter int MAX_PAY   = 1500,
    parameter int IFG_BITS  = 96,
    parameter int JAM_BITS  = 32,
    parameter int ADDR_W    = $clog2(HDR_BYTES + MAX_PAY)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  pay_len,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    input  logic              rx_en,
    input  logic              col,
    output logic              txd,
    output logic              tx_en,
    output logic              busy,
    output logic              done,
    output logic              col_flag,
    output logic              len_err
);
    import eth_tx_pkg::*;

    localparam int CNT_W    = $clog2((HDR_BYTES + MAX_PAY) * 8);
    localparam int PRE_BITS = 64;
    localparam int FCS_BITS = 32;

    tx_state_e         state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  plen;
    logic [CNT_W-1:0]  body_last;
    logic [CNT_W-1:0]  byte_idx;
    logic              in_data;
    logic              body_bit;
    logic [7:0]        pre_byte;
    logic              cs, quiet, fcs_bit;
    logic              crc_init, crc_upd, crc_shft;
    logic              len_bad;

    assign cs        = rx_en | col;
    assign len_bad   = (pay_len > LEN_W'(MAX_PAY));
    assign plen      = (len_q < LEN_W'(MIN_PAY)) ? LEN_W'(MIN_PAY) : len_q;
    assign body_last = (CNT_W'(plen) + CNT_W'(HDR_BYTES)) * CNT_W'(8) - CNT_W'(1);
    assign byte_idx  = cnt >> 3;
    assign in_data   = byte_idx < (CNT_W'(len_q) + CNT_W'(HDR_BYTES));
    assign body_bit  = in_data ? rd_data[cnt[2:0]] : 1'b0;
    assign pre_byte  = (cnt[5:3] == 3'd7) ? SFD_BYTE : PRE_BYTE;
    assign rd_addr   = ADDR_W'(byte_idx);

    etx_defer #(.IFG_BITS(IFG_BITS)) u_defer (
        .clk   (clk),
        .rst_n (rst_n),
        .cs    (cs),
        .quiet (quiet)
    );

    etx_crc32 u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (crc_init),
        .upd     (crc_upd),
        .shft    (crc_shft),
        .din     (body_bit),
        .fcs_bit (fcs_bit)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start && !len_bad) nxt = cs ? S_DEFER : S_PRE;
            S_DEFER: if (quiet) nxt = S_PRE;
            S_PRE:   if (col) nxt = S_JAM;
                     else if (cnt == CNT_W'(PRE_BITS - 1)) nxt = S_BODY;
            S_BODY:  if (col) nxt = S_JAM;
                     else if (cnt == body_last) nxt = S_FCS;
            S_FCS:   if (col) nxt = S_JAM;
                     else if (cnt == CNT_W'(FCS_BITS - 1)) nxt = S_FIN;
            S_JAM:   if (cnt == CNT_W'(JAM_BITS - 1)) nxt = S_FIN;
            S_FIN:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register, bit counter and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cnt      <= '0;
            len_q    <= '0;
            col_flag <= 1'b0;
            len_err  <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
            if (state == S_IDLE && start) begin
                len_q    <= pay_len;
                len_err  <= len_bad;
                col_flag <= 1'b0;
            end
            if (nxt == S_JAM && state != S_JAM) col_flag <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        txd      = 1'b0;
        tx_en    = 1'b0;
        done     = 1'b0;
        busy     = (state != S_IDLE);
        crc_init = 1'b0;
        crc_upd  = 1'b0;
        crc_shft = 1'b0;
        unique case (state)
            S_PRE:  begin txd = pre_byte[cnt[2:0]]; tx_en = 1'b1; crc_init = 1'b1; end
            S_BODY: begin txd = body_bit; tx_en = 1'b1; crc_upd = 1'b1; end
            S_FCS:  begin txd = fcs_bit;  tx_en = 1'b1; crc_shft = 1'b1; end
            S_JAM:  begin txd = ~cnt[0];  tx_en = 1'b1; end
            S_FIN:  done = 1'b1;
            default: ;
        endcase
    end

    // R1: after the 64th preamble bit with no collision, the body begins
    a_r1_pre_to_body: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PRE && cnt == CNT_W'(PRE_BITS - 1) && !col) |=> (state == S_BODY && cnt == '0));

    // R5: the done pulse always directly follows an enabled cycle
    a_r5_done_after_en: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(tx_en));

    // R6: leaving deferral requires the quiet timer
    a_r6_defer_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PRE && $past(state) == S_DEFER) |-> $past(quiet));

    // R8: the jam is exactly JAM_BITS long
    a_r8_jam_length: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_JAM && cnt == CNT_W'(JAM_BITS - 1)) |=> (state == S_FIN));

    // R8: the collision flag rises only on entry to the jam
    a_r8_flag_on_jam: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_flag) |-> (state == S_JAM));

    // R9: a rejected request never drives the line
    a_r9_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> !tx_en);

endmodule

// File: tb/sim_eth_ser_tx.sv
module sim_eth_ser_tx;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, start, rx_en, col;
    logic [10:0] pay_len;
    logic [10:0] rd_addr;
    logic [7:0]  rd_data;
    logic        txd, tx_en, busy, done, col_flag, len_err;
    logic [7:0]  mem [0:2047];

    int n_chk = 0;
    int n_bad = 0;

    // fields: len[39:24] seed[23:16] collision-bit-index[15:0] (0 = none)
    localparam logic [39:0] VEC [0:8] = '{
        {16'd0,    8'd1, 16'd0},
        {16'd1,    8'd2, 16'd0},
        {16'd45,   8'd3, 16'd0},
        {16'd46,   8'd4, 16'd0},
        {16'd47,   8'd5, 16'd0},
        {16'd128,  8'd6, 16'd0},
        {16'd1500, 8'd7, 16'd0},
        {16'd60,   8'd8, 16'd20},
        {16'd60,   8'd9, 16'd300}
    };

    always #(PERIOD/2) clk = ~clk;
    assign rd_data = mem[rd_addr];

    eth_ser_tx u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pay_len(pay_len),
        .rd_addr(rd_addr), .rd_data(rd_data), .rx_en(rx_en), .col(col),
        .txd(txd), .tx_en(tx_en), .busy(busy), .done(done),
        .col_flag(col_flag), .len_err(len_err)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 2048; i++) mem[i] = 8'(seed * 37 + i * 7 + (i >> 4));
    endtask

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic b);
        return (c >> 1) ^ ((c[0] ^ b) ? 32'hEDB88320 : 32'h0);
    endfunction

    task automatic run_frame(input int len, input int seed, input int colk);
        int plen, total, n, bi, bp;
        int pre_bad, body_bad, pad_bad, jam_bad;
        logic [31:0] crc;
        logic [7:0]  eb;
        fill(seed);
        plen = (len < 46) ? 46 : len;
        total = (8 + 14 + plen + 4) * 8;
        pre_bad = 0; body_bad = 0; pad_bad = 0; jam_bad = 0;
        crc = 32'hFFFFFFFF;
        n = 0;
        @(negedge clk);
        pay_len = 11'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(tx_en == 1'b1, "R1 tx_en one cycle after start", tx_en, 1);
        while (tx_en && n < 20000) begin
            bi = n / 8;
            bp = n % 8;
            if (colk != 0 && n >= colk) begin
                if (txd != (((n - colk) % 2) == 0)) jam_bad++;
            end else if (bi < 8) begin
                eb = (bi == 7) ? 8'hD5 : 8'h55;
                if (txd != eb[bp]) pre_bad++;
            end else if (bi - 8 < 14 + len) begin
                eb = mem[bi - 8];
                if (txd != eb[bp]) body_bad++;
            end else if (bi - 8 < 14 + plen) begin
                if (txd != 1'b0) pad_bad++;
            end
            if (bi >= 8) crc = crc_step(crc, txd);
            n++;
            col = (colk != 0 && n == colk);
            @(negedge clk);
        end
        col = 1'b0;
        chk(pre_bad == 0, "R1 preamble and delimiter bits", pre_bad, 0);
        chk(body_bad == 0, "R2 buffered bytes in order LSB first", body_bad, 0);
        if (colk == 0) begin
            chk(pad_bad == 0, "R3 padding bytes are zero", pad_bad, 0);
            chk(n == total, "R5 enable length equals padded frame", n, total);
            chk(crc == 32'hDEBB20E3, "R4 CRC residue over frame", crc, 32'hDEBB20E3);
            chk(col_flag == 1'b0, "R8 no collision flag on clean frame", col_flag, 0);
        end else begin
            chk(jam_bad == 0, "R8 jam pattern bits", jam_bad, 0);
            chk(n == colk + 32, "R8 enable length with jam", n, colk + 32);
            chk(col_flag == 1'b1, "R8 collision flag set", col_flag, 1);
        end
        chk(done == 1'b1, "R5 done after last bit", done, 1);
        chk(len_err == 1'b0, "R9 legal request clears len_err", len_err, 0);
        @(negedge clk);
        chk(done == 1'b0, "R5 done is a single cycle", done, 0);
    endtask

    task automatic run_defer(input bit use_col);
        bit ok;
        int j;
        fill(11);
        @(negedge clk);
        rx_en = !use_col;
        col = use_col;
        pay_len = 11'd50;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ok = 1'b1;
        repeat (40) begin
            if (tx_en) ok = 1'b0;
            @(negedge clk);
        end
        if (use_col) chk(ok, "R7 collision alone defers", !ok, 0);
        else         chk(ok, "R6 receive enable defers", !ok, 0);
        rx_en = 1'b0;
        col = 1'b0;
        j = 0;
        while (!tx_en && j < 500) begin
            @(negedge clk);
            j++;
        end
        if (use_col) chk(j == 97, "R7 restart after collision carrier", j, 97);
        else         chk(j == 97, "R6 restart after interframe gap", j, 97);
        j = 0;
        while (tx_en && j < 20000) begin
            @(negedge clk);
            j++;
        end
        chk(j == (8 + 14 + 50 + 4) * 8, "R6 deferred frame length", j, (8 + 14 + 50 + 4) * 8);
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit ok;
        rst_n = 1'b0; start = 1'b0; rx_en = 1'b0; col = 1'b0; pay_len = '0;
        fill(0);
        repeat (3) @(negedge clk);
        // R10: reset state
        chk({txd, tx_en, busy, done, col_flag, len_err} == 6'b0,
            "R10 outputs low in reset", {txd, tx_en, busy, done, col_flag, len_err}, 0);
        rst_n = 1'b1;
        repeat (100) @(negedge clk);

        for (int v = 0; v < 9; v++) begin
            run_frame(int'(VEC[v][39:24]), int'(VEC[v][23:16]), int'(VEC[v][15:0]));
        end

        run_defer(1'b0);
        run_defer(1'b1);

        // R9: oversize request
        @(negedge clk);
        pay_len = 11'd1501;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(len_err == 1'b1, "R9 oversize sets len_err", len_err, 1);
        ok = 1'b1;
        repeat (30) begin
            if (tx_en || busy || done) ok = 1'b0;
            @(negedge clk);
        end
        chk(ok, "R9 oversize sends nothing", !ok, 0);
        run_frame(10, 12, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule